// File: doc/BRIEF.md
# Debounced Level-Interrupt Input Bank

This block watches eight external input lines and turns each one into a clean, debounced level. It can also raise an interrupt when a line settles at a chosen level. Each raw input first passes through a two-stage synchronizer. A per-line counter then advances on a millisecond clock-enable pulse, and only a value that holds steady for the programmed number of milliseconds is accepted as the line's new stable level.

Software programs the block through a simple read/write register bus with a combinational read path. The registers select, per line:

- the debounce window;
- which stable levels appear in the readback register;
- which level counts as an event;
- whether events may be latched.

Capture needs a one-shot arm bit. The hardware clears this bit when it latches an event, so software must re-arm the line after every event. Latched events are cleared by writing ones. The enabled latched events are combined into one interrupt output.

Top module: `dbirq_bank`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq` is low. The stable level of every line is 0.
- R2: The data register at offset 0x00 reads the stable level of line i in bit i, ANDed with bit i of the data mask at offset 0x04. Lines that are masked off read 0.
- R3: A line's stable level takes the synchronized input value only after that value has differed from the stable level during W consecutive millisecond ticks. W is the low 12 bits of the line's control word. If the input returns to the stable level first, the count restarts from zero.
- R4: A debounce window of 0 behaves exactly like a window of 1.
- R5: The control word of line i is at offset 0x40 + 4*i. Its low 12 bits are read/write. Its upper 20 bits always read 0, and writes to them are ignored.
- R6: An event is captured on line i when these three conditions hold together:
  - arm bit i (offset 0x28) is 1;
  - enable bit i (offset 0x18) is 1;
  - the stable level equals polarity bit i (offset 0x14; 1 selects high, 0 selects low).

  On the clock edge that captures the event, raw-status bit i (offset 0x1C) sets and arm bit i clears.
- R7: While the arm bit or the enable bit of a line is 0, raw status for that line does not set, and a set arm bit stays set.
- R8: Masked status (offset 0x20) equals raw status ANDed with enable. `irq` is the OR of all masked-status bits.
- R9: Writing 1 to bit i of the clear register (offset 0x24) clears raw-status bit i, and zero bits leave raw status unchanged. The clear register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle millisecond clock-enable pulse |
| line_in | input | 8 | Asynchronous external input lines |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Combined interrupt |

## Verification
The block has the following latencies:

- **Input change:** reaches the synchronized value two clock edges after it is applied.
- **Stable level and data readback:** change on the edge of the W-th qualifying tick. The data register shows the new level as soon as that edge has passed.
- **Raw status, arm self-clear and `irq`:** follow one edge after the stable level, or one edge after the register write that completes the capture condition.

The bench lets three cycles pass after each input change before it sends any tick. It drives each tick for exactly one cycle and reads registers at the falling edge, at least one cycle after the edge that updates them. This lets it check both the tick just before a window ends and the tick that ends it.

// File: rtl/dbirq_pkg.sv
package dbirq_pkg;

    localparam int N_LINES  = 8;
    localparam int WIN_BITS = 12;
    localparam int BUS_AW   = 8;
    localparam int BUS_DW   = 32;

    localparam logic [BUS_AW-1:0] OFS_DATA   = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_DMASK  = 8'h04;
    localparam logic [BUS_AW-1:0] OFS_POL    = 8'h14;
    localparam logic [BUS_AW-1:0] OFS_EN     = 8'h18;
    localparam logic [BUS_AW-1:0] OFS_RAW    = 8'h1C;
    localparam logic [BUS_AW-1:0] OFS_MASKED = 8'h20;
    localparam logic [BUS_AW-1:0] OFS_CLR    = 8'h24;
    localparam logic [BUS_AW-1:0] OFS_ARM    = 8'h28;
    localparam int                CTRL_BASE  = 'h40;

    typedef struct packed {
        logic              sel;
        logic              we;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] wdata;
    } bus_req_t;

    function automatic logic [WIN_BITS-1:0] eff_window(input logic [WIN_BITS-1:0] w);
        return (w == '0) ? WIN_BITS'(1) : w;
    endfunction

endpackage

// File: rtl/dbirq_sync.sv
module dbirq_sync #(
    parameter int LINES = dbirq_pkg::N_LINES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] async_in,
    output logic [LINES-1:0] sync_out
);
    logic [LINES-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/dbirq_filter.sv
module dbirq_filter
    import dbirq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                sample,
    input  logic [WIN_BITS-1:0] window,
    output logic                level
);
    logic [WIN_BITS-1:0] cnt;
    logic [WIN_BITS:0]   next_cnt;
    logic [WIN_BITS-1:0] limit;

    assign limit    = eff_window(window);
    assign next_cnt = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
            cnt   <= '0;
        end else if (sample == level) begin
            cnt <= '0;
        end else if (tick) begin
            if (next_cnt >= {1'b0, limit}) begin
                level <= sample;
                cnt   <= '0;
            end else begin
                cnt <= next_cnt[WIN_BITS-1:0];
            end
        end
    end

    // R3
    level_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(level) |-> $past(tick));

    // R3
    level_follows_input_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(level) |-> (level == $past(sample)));
endmodule

// File: rtl/dbirq_regs.sv
module dbirq_regs
    import dbirq_pkg::*;
#(
    parameter int LINES = N_LINES
) (
    input  logic                            clk,
    input  logic                            rst,
    input  bus_req_t                        req,
    input  logic [LINES-1:0]                stable,
    output logic [BUS_DW-1:0]               rdata,
    output logic [LINES-1:0][WIN_BITS-1:0]  window,
    output logic                            irq
);
    logic [LINES-1:0] dmask, pol, en, arm, raw;
    logic [LINES-1:0] capture, clr_bits, masked;
    logic             wr;

    assign wr       = req.sel && req.we;
    assign capture  = arm & en & ~(stable ^ pol);
    assign clr_bits = (wr && req.addr == OFS_CLR) ? req.wdata[LINES-1:0] : '0;
    assign masked   = raw & en;
    assign irq      = |masked;

    always_ff @(posedge clk) begin
        if (rst) begin
            dmask  <= '0;
            pol    <= '0;
            en     <= '0;
            arm    <= '0;
            raw    <= '0;
            window <= '0;
        end else begin
            raw <= (raw & ~clr_bits) | capture;
            if (wr && req.addr == OFS_ARM) arm <= req.wdata[LINES-1:0] & ~capture;
            else                           arm <= arm & ~capture;
            if (wr && req.addr == OFS_DMASK) dmask <= req.wdata[LINES-1:0];
            if (wr && req.addr == OFS_POL)   pol   <= req.wdata[LINES-1:0];
            if (wr && req.addr == OFS_EN)    en    <= req.wdata[LINES-1:0];
            for (int i = 0; i < LINES; i++) begin
                if (wr && req.addr == BUS_AW'(CTRL_BASE + 4 * i))
                    window[i] <= req.wdata[WIN_BITS-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (req.addr)
            OFS_DATA:   rdata = {{(BUS_DW-LINES){1'b0}}, stable & dmask};
            OFS_DMASK:  rdata = {{(BUS_DW-LINES){1'b0}}, dmask};
            OFS_POL:    rdata = {{(BUS_DW-LINES){1'b0}}, pol};
            OFS_EN:     rdata = {{(BUS_DW-LINES){1'b0}}, en};
            OFS_RAW:    rdata = {{(BUS_DW-LINES){1'b0}}, raw};
            OFS_MASKED: rdata = {{(BUS_DW-LINES){1'b0}}, masked};
            OFS_ARM:    rdata = {{(BUS_DW-LINES){1'b0}}, arm};
            default: begin
                for (int i = 0; i < LINES; i++) begin
                    if (req.addr == BUS_AW'(CTRL_BASE + 4 * i))
                        rdata = {{(BUS_DW-WIN_BITS){1'b0}}, window[i]};
                end
            end
        endcase
    end

    // R6 R7
    capture_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        ((raw & ~$past(raw)) & ~$past(arm & en)) == '0);

    // R6
    arm_drops_on_capture_chk: assert property (@(posedge clk) disable iff (rst)
        ((raw & ~$past(raw)) & arm) == '0);

    // R8
    irq_has_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (raw != '0));
endmodule

// File: rtl/dbirq_bank.sv
module dbirq_bank
    import dbirq_pkg::*;
#(
    parameter int LINES = N_LINES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ms_tick,
    input  logic [LINES-1:0]  line_in,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              irq
);
    logic [LINES-1:0]               synced;
    logic [LINES-1:0]               stable;
    logic [LINES-1:0][WIN_BITS-1:0] window;
    bus_req_t                       req;

    assign req = '{sel: bus_sel, we: bus_we, addr: bus_addr, wdata: bus_wdata};

    dbirq_sync #(.LINES(LINES)) u_sync (
        .clk(clk), .rst(rst), .async_in(line_in), .sync_out(synced)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_line
        dbirq_filter u_filter (
            .clk(clk), .rst(rst), .tick(ms_tick),
            .sample(synced[g]), .window(window[g]), .level(stable[g])
        );
    end

    dbirq_regs #(.LINES(LINES)) u_regs (
        .clk(clk), .rst(rst), .req(req), .stable(stable),
        .rdata(bus_rdata), .window(window), .irq(irq)
    );
endmodule

// File: tb/test_dbirq_bank.sv
module test_dbirq_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ms_tick = 1'b0;
    logic [7:0]  lin = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    dbirq_bank i_dbirq_bank (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .line_in(lin),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        cycles(3);
        rst = 1'b0;
        cycles(2);

        // R1: reset values
        foreach (i_addr[k]) begin end
        for (int a = 0; a < 8'h60; a += 4) begin
            rd(8'(a), v);
            check("R1 reset register", v, 32'h0);
        end
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R5: control words keep low 12 bits only
        for (int i = 0; i < 8; i++) begin
            wr(8'(8'h40 + 4 * i), 32'hABCDE000 | 32'(i * 291 + 7));
            rd(8'(8'h40 + 4 * i), v);
            check("R5 control word", v, 32'(i * 291 + 7) & 32'hFFF);
        end

        // R3 R4 R2: per-line window sweep, window = line index
        wr(8'h04, 32'hFF);
        for (int i = 0; i < 8; i++) begin
            int eff;
            eff = (i == 0) ? 1 : i;
            wr(8'(8'h40 + 4 * i), 32'(i));
            @(negedge clk); lin[i] = 1'b1;
            cycles(3);
            if (eff > 1) begin
                ticks(eff - 1);
                rd(8'h00, v);
                check("R3 before window end", v, 32'((1 << i) - 1));
            end
            ticks(1);
            rd(8'h00, v);
            check(i == 0 ? "R4 zero window" : "R3 at window end", v, 32'((1 << (i + 1)) - 1));
        end

        // R3: early return restarts the count (line 3, window 4)
        wr(8'h4C, 32'd4);
        @(negedge clk); lin[3] = 1'b0; cycles(3);
        ticks(3);
        @(negedge clk); lin[3] = 1'b1; cycles(3);
        ticks(2);
        @(negedge clk); lin[3] = 1'b0; cycles(3);
        ticks(3);
        rd(8'h00, v);
        check("R3 restart still high", v, 32'hFF);
        ticks(1);
        rd(8'h00, v);
        check("R3 restart window done", v, 32'hF7);

        // R2: mask selects readback
        wr(8'h04, 32'h0F);
        rd(8'h00, v);
        check("R2 mask 0F", v, 32'h07);
        wr(8'h04, 32'h00);
        rd(8'h00, v);
        check("R2 mask 00", v, 32'h00);

        // R7: no capture without enable, then without arm
        wr(8'h14, 32'hFF);
        wr(8'h28, 32'hFF);
        cycles(3);
        rd(8'h1C, v); check("R7 raw no enable", v, 32'h0);
        rd(8'h28, v); check("R7 arm kept", v, 32'hFF);
        wr(8'h28, 32'h00);
        wr(8'h18, 32'hFF);
        cycles(3);
        rd(8'h1C, v); check("R7 raw no arm", v, 32'h0);
        check("R7 irq low", {31'b0, irq}, 32'h0);

        // R6: low-level capture on line 3, polarity mismatch on line 6
        wr(8'h14, 32'hB7);
        wr(8'h28, 32'h48);
        cycles(2);
        rd(8'h1C, v); check("R6 low level capture", v, 32'h08);
        rd(8'h28, v); check("R6 arm self clear", v, 32'h40);
        wr(8'h28, 32'h01);
        cycles(2);
        rd(8'h1C, v); check("R6 high level capture", v, 32'h09);
        rd(8'h28, v); check("R6 arm cleared", v, 32'h00);

        // R8: masked status and irq
        rd(8'h20, v); check("R8 masked all", v, 32'h09);
        check("R8 irq high", {31'b0, irq}, 32'h1);
        wr(8'h18, 32'h08);
        rd(8'h20, v); check("R8 masked partial", v, 32'h08);
        wr(8'h18, 32'h00);
        rd(8'h20, v); check("R8 masked none", v, 32'h00);
        check("R8 irq low", {31'b0, irq}, 32'h0);
        rd(8'h1C, v); check("R8 raw kept", v, 32'h09);

        // R9: write-one-to-clear
        wr(8'h24, 32'hF6);
        rd(8'h1C, v); check("R9 zero bits no effect", v, 32'h09);
        wr(8'h24, 32'h01);
        rd(8'h1C, v); check("R9 clear line 0", v, 32'h08);
        rd(8'h24, v); check("R9 clear reads zero", v, 32'h0);
        wr(8'h24, 32'h08);
        rd(8'h1C, v); check("R9 clear line 3", v, 32'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    int i_addr[1];
endmodule